// File: doc/BRIEF.md
# DDR Byte-Link Transmitter

This block sends 32-bit words over an 8-bit point-to-point link. A strobe line, the outgoing link clock, toggles once for every byte. Because the receiver latches on both the rising and the falling edge, two bytes move per link-clock period. Each word goes out as four bytes, least significant first, which takes two full link-clock periods. The core writes words through a valid/ready port into a holding register. A separate shift stage sends the current word, so the next word can be loaded while the current one is still on the wire.

Traffic is grouped into packets, and the packet length in words is programmable. The remote side returns an acknowledge level that gates the start of every packet. If enabled, an 8-bit modulo-256 sum of all payload bytes follows the packet as one extra byte. A speed field sets how many core cycles each byte is held on the bus. A direction output steers external bus buffers. When the far end asks for a token switch, the transmitter finishes any packet in progress and then releases the bus to take the receive role.

Top module: `lktx_top`

## Requirements
- R1: While reset is asserted and directly after it, `lk_clk_out` is 0, `lk_dat_out` is 0x00, `lk_dir_out` is 1 (transmit) and `wr_ready` is 1.
- R2: Each toggle of `lk_clk_out`, rising or falling, presents exactly one new byte on `lk_dat_out`. A word goes out as bits [7:0], [15:8], [23:16], [31:24], in that order.
- R3: The four bytes of one word are spaced 2^`cfg_spd` core cycles apart: code 0 gives 1 cycle, 1 gives 2, 2 gives 4 and 3 gives 8.
- R4: `wr_ready` is 1 exactly when the holding register is empty. A write with `wr_valid` and `wr_ready` both high fills it. Once a word moves into the shift stage, the holding register frees up while that word is still being sent.
- R5: A packet holds `cfg_len`+1 words. A packet starts only while `lk_ack_in` is 1. While idle with `lk_ack_in` at 0, `lk_clk_out` does not toggle, even with a word waiting.
- R6: With `cfg_cks_en` at 1, one extra byte follows the last payload byte of a packet. It equals the sum of that packet's payload bytes modulo 256. With `cfg_cks_en` at 0, no extra byte is sent.
- R7: When `tok_req` is 1 at a packet boundary, `lk_dir_out` goes to 0 one cycle later. While it is 0, `lk_dat_out` is 0x00 and `lk_clk_out` holds. A packet already in progress completes first. Transmit resumes once `tok_req` returns to 0.
- R8: If the next word of a packet has not been written yet, `lk_clk_out` holds after the last byte of the current word until the word arrives.
- R9: While `lk_dir_out` stays 1, `lk_dat_out` changes only in a cycle where `lk_clk_out` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Core offers a word |
| wr_data | input | 32 | Word to send |
| wr_ready | output | 1 | Holding register empty |
| cfg_spd | input | 2 | Byte period select, 2^code core cycles |
| cfg_len | input | 4 | Words per packet minus one |
| cfg_cks_en | input | 1 | Append checksum byte |
| lk_ack_in | input | 1 | Acknowledge from the receiver |
| tok_req | input | 1 | Far end requests the bus |
| lk_clk_out | output | 1 | Link clock, one toggle per byte |
| lk_dat_out | output | 8 | Link data byte |
| lk_dir_out | output | 1 | 1 = transmitting, 0 = receive role |

## Verification
The bench aims at the following corner cases and the fault each one exposes.
- Byte order and per-edge pacing at all four speed codes: a swapped byte lane, or a divider that is off by one, would show up as wrong bytes or wrong spacing in the scoreboard.
- Checksums whose sum wraps past 255: a design that kept a wider sum or counted the wrong bytes would send a bad trailing byte. With the checksum disabled, a stray trailing byte would appear as an unexpected toggle.
- Acknowledge held low with a word waiting: a design that ignored the gate would start sending.
- Token request raised in the middle of a packet: a design that released the bus at once would cut the packet short.
- A packet whose second word arrives late: a design that did not stall would emit bytes with no data behind them.

// File: rtl/lktx_pkg.sv
package lktx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CKS  = 2'd2
    } lktx_state_e;

endpackage

// File: rtl/lktx_hold.sv
module lktx_hold #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              take,
    output logic [WORD_W-1:0] hold_data,
    output logic              hold_vld
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.vld = 1'b0;
        end
        if (wr_valid && !hold_q.vld) begin
            hold_d.vld  = 1'b1;
            hold_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign wr_ready  = !hold_q.vld;
    assign hold_data = hold_q.data;
    assign hold_vld  = hold_q.vld;

endmodule

// File: rtl/lktx_pacer.sv
module lktx_pacer #(
    parameter int SPD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] spd,
    input  logic             fire,
    output logic             slot_end
);

    localparam int CNT_W = (1 << SPD_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pace_t;

    pace_t pace_d, pace_q;

    always_comb begin
        pace_d = pace_q;
        if (fire) begin
            pace_d.cnt = CNT_W'((1 << spd) - 1);
        end else if (pace_q.cnt != '0) begin
            pace_d.cnt = pace_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pace_q <= '0;
        end else begin
            pace_q <= pace_d;
        end
    end

    assign slot_end = (pace_q.cnt == '0);

endmodule

// File: rtl/lktx_top.sv
module lktx_top
    import lktx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 4,
    parameter int SPD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic [SPD_W-1:0]  cfg_spd,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_cks_en,
    input  logic              lk_ack_in,
    input  logic              tok_req,
    output logic              lk_clk_out,
    output logic [7:0]        lk_dat_out,
    output logic              lk_dir_out
);

    localparam int NBYTES = WORD_W / 8;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        lktx_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  wcnt;
        logic [WORD_W-1:0] sh;
        logic [7:0]        cks;
        logic              lclk;
        logic [7:0]        dat;
        logic              dir;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              take;
    logic              fire;
    logic [7:0]        emit_byte;
    logic [WORD_W-1:0] hold_data;
    logic              hold_vld;
    logic              slot_end;
    logic              seq_idle;

    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                             input logic [IDX_W-1:0]  i);
        return 8'(w >> (8 * int'(i)));
    endfunction

    lktx_hold #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .take      (take),
        .hold_data (hold_data),
        .hold_vld  (hold_vld)
    );

    lktx_pacer #(.SPD_W(SPD_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .spd      (cfg_spd),
        .fire     (fire),
        .slot_end (slot_end)
    );

    always_comb begin
        seq_d     = seq_q;
        take      = 1'b0;
        fire      = 1'b0;
        emit_byte = 8'h00;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (!tok_req && lk_ack_in && hold_vld) begin
                    take       = 1'b1;
                    fire       = 1'b1;
                    emit_byte  = hold_data[7:0];
                    seq_d.sh   = hold_data;
                    seq_d.idx  = '0;
                    seq_d.wcnt = '0;
                    seq_d.cks  = hold_data[7:0];
                    seq_d.st   = ST_DATA;
                end
            end
            ST_DATA: begin
                if (slot_end) begin
                    if (seq_q.idx != IDX_W'(NBYTES - 1)) begin
                        fire      = 1'b1;
                        seq_d.idx = seq_q.idx + IDX_W'(1);
                        emit_byte = pick_byte(seq_q.sh, seq_d.idx);
                        seq_d.cks = seq_q.cks + emit_byte;
                    end else if (seq_q.wcnt != cfg_len) begin
                        if (hold_vld) begin
                            take       = 1'b1;
                            fire       = 1'b1;
                            emit_byte  = hold_data[7:0];
                            seq_d.sh   = hold_data;
                            seq_d.idx  = '0;
                            seq_d.wcnt = seq_q.wcnt + LEN_W'(1);
                            seq_d.cks  = seq_q.cks + emit_byte;
                        end
                    end else if (cfg_cks_en) begin
                        fire      = 1'b1;
                        emit_byte = seq_q.cks;
                        seq_d.st  = ST_CKS;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            ST_CKS: begin
                if (slot_end) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase

        if (fire) begin
            seq_d.lclk = ~seq_q.lclk;
            seq_d.dat  = emit_byte;
        end

        seq_d.dir = !((seq_d.st == ST_IDLE) && tok_req);
        if (!seq_d.dir) begin
            seq_d.dat = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.dir  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seq_idle   = (seq_q.st == ST_IDLE);
    assign lk_clk_out = seq_q.lclk;
    assign lk_dat_out = seq_q.dat;
    assign lk_dir_out = seq_q.dir;

endmodule

// File: rtl/lktx_chk.sv
module lktx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       lk_ack_in,
    input logic       tok_req,
    input logic       lk_clk_out,
    input logic [7:0] lk_dat_out,
    input logic       lk_dir_out,
    input logic       idle
);

    assert_hold_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    assert_ack_gates_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !lk_ack_in) |=> $stable(lk_clk_out));

    assert_bus_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_dir_out |-> (lk_dat_out == 8'h00));

    assert_clk_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_dir_out && !$past(lk_dir_out)) |-> $stable(lk_clk_out));

    assert_token_yields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && tok_req) |=> !lk_dir_out);

    assert_dat_with_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_dir_out && $past(lk_dir_out) && $stable(lk_clk_out)) |-> $stable(lk_dat_out));

endmodule

bind lktx_top lktx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .lk_ack_in  (lk_ack_in),
    .tok_req    (tok_req),
    .lk_clk_out (lk_clk_out),
    .lk_dat_out (lk_dat_out),
    .lk_dir_out (lk_dir_out),
    .idle       (seq_idle)
);

// File: tb/lktx_top_tb.sv
module lktx_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic [1:0]  cfg_spd = 2'd0;
    logic [3:0]  cfg_len = 4'd0;
    logic        cfg_cks_en = 1'b0;
    logic        lk_ack_in = 1'b1;
    logic        tok_req = 1'b0;
    logic        lk_clk_out;
    logic [7:0]  lk_dat_out;
    logic        lk_dir_out;

    always #10 clk = ~clk;

    lktx_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .cfg_spd    (cfg_spd),
        .cfg_len    (cfg_len),
        .cfg_cks_en (cfg_cks_en),
        .lk_ack_in  (lk_ack_in),
        .tok_req    (tok_req),
        .lk_clk_out (lk_clk_out),
        .lk_dat_out (lk_dat_out),
        .lk_dir_out (lk_dir_out)
    );

    typedef struct {
        logic [7:0] b;
        bit         gap;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   tog_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected bytes at every link-clock toggle
    logic       prev_clk = 1'b0;
    logic [7:0] prev_dat = 8'h00;
    logic       prev_dir = 1'b1;
    int         since = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (lk_clk_out != prev_clk) begin
                tog_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected byte", int'(lk_dat_out), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(lk_dat_out == e.b, e.req, "byte value", int'(lk_dat_out), int'(e.b));
                    if (e.gap) begin
                        chk(since + 1 == (1 << cfg_spd), "R3", "byte spacing",
                            since + 1, 1 << cfg_spd);
                    end
                end
                since = 0;
            end else begin
                since++;
                if (lk_dir_out && prev_dir) begin
                    chk(lk_dat_out == prev_dat, "R9", "data moved without edge",
                        int'(lk_dat_out), int'(prev_dat));
                end
            end
        end
        prev_clk = lk_clk_out;
        prev_dat = lk_dat_out;
        prev_dir = lk_dir_out;
    end

    task automatic wr_word(input logic [31:0] w);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w, input string req,
                             inout logic [7:0] sum);
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            e.b   = w[8*k +: 8];
            e.gap = (k != 0);
            e.req = req;
            exp_q.push_back(e);
            sum = sum + w[8*k +: 8];
        end
    endtask

    task automatic send_pkt(input int nw, input logic [31:0] seed, input string req);
        logic [7:0] sum;
        sum = 8'h00;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] word;
            word = seed ^ (32'(w) * 32'h9E37_79B9);
            push_word(word, req, sum);
            wr_word(word);
        end
        if (cfg_cks_en) begin
            exp_t e;
            e.b = sum; e.gap = 1'b0; e.req = "R6";
            exp_q.push_back(e);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        chk(exp_q.size() == 0, "R2", "bytes left unsent", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t0;
        logic [7:0] s;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(lk_clk_out == 1'b0, "R1", "clk in reset", int'(lk_clk_out), 0);
        chk(lk_dat_out == 8'h00, "R1", "dat in reset", int'(lk_dat_out), 0);
        chk(lk_dir_out == 1'b1, "R1", "dir in reset", int'(lk_dir_out), 1);
        chk(wr_ready == 1'b1, "R1", "ready in reset", int'(wr_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(lk_clk_out == 1'b0 && lk_dir_out == 1'b1, "R1", "after reset",
            int'({lk_clk_out, lk_dir_out}), 1);

        // R2: single word, fastest speed, no checksum
        cfg_spd = 2'd0; cfg_len = 4'd0; cfg_cks_en = 1'b0;
        send_pkt(1, 32'h4433_2211, "R2");
        drain();

        // R3 / R5 / R6: three words, speed 2, checksum
        cfg_spd = 2'd2; cfg_len = 4'd2; cfg_cks_en = 1'b1;
        send_pkt(3, 32'hA5C3_0F81, "R5");
        drain();

        // R3: speed 3, two words
        cfg_spd = 2'd3; cfg_len = 4'd1; cfg_cks_en = 1'b0;
        send_pkt(2, 32'h1357_9BDF, "R3");
        drain();

        // R6: checksum wrap with large bytes, speed 1
        cfg_spd = 2'd1; cfg_len = 4'd1; cfg_cks_en = 1'b1;
        send_pkt(2, 32'hFFFE_FDFC, "R6");
        drain();

        // R5: acknowledge low blocks start
        cfg_spd = 2'd0; cfg_len = 4'd0; cfg_cks_en = 1'b0;
        lk_ack_in = 1'b0;
        t0 = tog_cnt;
        s = 8'h00;
        push_word(32'hDEAD_BEEF, "R5", s);
        wr_word(32'hDEAD_BEEF);
        repeat (30) @(negedge clk);
        chk(tog_cnt == t0, "R5", "toggles while ack low", tog_cnt - t0, 0);
        chk(wr_ready == 1'b0, "R4", "holding full while blocked", int'(wr_ready), 0);
        lk_ack_in = 1'b1;
        drain();
        chk(tog_cnt == t0 + 4, "R5", "word sent after ack", tog_cnt - t0, 4);

        // R7: token request while idle
        tok_req = 1'b1;
        repeat (2) @(negedge clk);
        chk(lk_dir_out == 1'b0, "R7", "dir released", int'(lk_dir_out), 0);
        chk(lk_dat_out == 8'h00, "R7", "bus zero", int'(lk_dat_out), 0);
        t0 = tog_cnt;
        s = 8'h00;
        push_word(32'h0BAD_F00D, "R7", s);
        wr_word(32'h0BAD_F00D);
        repeat (20) @(negedge clk);
        chk(tog_cnt == t0, "R7", "toggles in receive role", tog_cnt - t0, 0);
        tok_req = 1'b0;
        drain();
        chk(lk_dir_out == 1'b1, "R7", "dir back to transmit", int'(lk_dir_out), 1);

        // R7: token request mid-packet, packet completes first
        cfg_spd = 2'd2; cfg_len = 4'd1;
        s = 8'h00;
        push_word(32'h7766_5544, "R7", s);
        wr_word(32'h7766_5544);
        t0 = tog_cnt;
        while (tog_cnt == t0) @(negedge clk);
        tok_req = 1'b1;
        @(negedge clk);
        chk(lk_dir_out == 1'b1, "R7", "dir held mid-packet", int'(lk_dir_out), 1);
        push_word(32'hBBAA_9988, "R7", s);
        wr_word(32'hBBAA_9988);
        drain();
        chk(lk_dir_out == 1'b0, "R7", "dir released after packet", int'(lk_dir_out), 0);
        chk(lk_dat_out == 8'h00, "R7", "bus zero after packet", int'(lk_dat_out), 0);
        tok_req = 1'b0;
        repeat (3) @(negedge clk);

        // R8: underflow inside a packet
        cfg_spd = 2'd1; cfg_len = 4'd1;
        t0 = tog_cnt;
        s = 8'h00;
        push_word(32'h3322_1100, "R8", s);
        wr_word(32'h3322_1100);
        repeat (3) @(negedge clk);
        chk(wr_ready == 1'b1, "R4", "holding free while sending", int'(wr_ready), 1);
        repeat (40) @(negedge clk);
        chk(tog_cnt == t0 + 4, "R8", "clock held waiting for word", tog_cnt - t0, 4);
        push_word(32'h7766_5544, "R8", s);
        wr_word(32'h7766_5544);
        drain();
        chk(tog_cnt == t0 + 8, "R8", "second word sent", tog_cnt - t0, 8);

        finish_run();
    end

endmodule